// File: doc/BRIEF.md
# Dual Input-Clock Loss-of-Signal Monitor

This block checks, from a free-running reference clock, whether each of two monitored input clocks is still toggling. Each monitored clock flips a private toggle flop. That toggle is carried into the reference domain by a synchroniser chain, and an edge detector turns each change into a one-cycle pulse. A per-channel inactivity counter restarts on every pulse. If the counter runs a full window of reference cycles without a pulse, the channel's flag goes high, meaning the clock is absent. The next detected pulse clears the flag. Setting is therefore slow and clearing is fast.

The window length is derived from two parameters: the reference frequency in MHz and the window length in nanoseconds. The defaults are 250 MHz and 15000 ns, which give 3750 reference cycles. The two channels share only the reference clock and the reset. Software or a clock-selection block reads the flags directly; both flags are registered.

Top module: `lossig_monitor`

## Requirements
- R1: After reset is released, each flag reads 1 and stays 1 until the first rising edge of its own monitored clock has been detected.
- R2: When a rising edge of a monitored clock falls inside reference cycle c (after reference edge c), that channel's flag is 0 from reference edge c+3 on.
- R3: With T = REF_MHZ*WINDOW_NS/1000 (3750 by default), a flag whose last monitored rising edge fell in cycle c rises at reference edge c+3+T. An edge in cycle c+T keeps the flag low. An edge in cycle c+T+1 leaves the flag high for exactly one cycle.
- R4: The two channels are independent: stopping, starting or pulsing one monitored clock never changes the other channel's flag.
- R5: While a monitored clock runs with rising edges at least 4 and at most T reference cycles apart, its flag stays 0. This covers a 1 MHz clock against the 250 MHz reference.
- R6: Asserting the active-low reset drives both flags to 1 at once. Monitored edges that arrive while reset is low have no effect. After release, the channels behave as after a first reset (R1, R2).
- R7: Once a flag is 1, it holds at 1 on every cycle in which no monitored edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | NUM_INPUTS | Monitored clocks, one bit per channel |
| los_o | output | NUM_INPUTS | Registered loss flags, 1 = clock absent |

## Verification
The bench times flag transitions to the exact reference cycle: the clear three edges after a monitored edge, and the set T+3 edges after the last one. A design with an extra or missing synchroniser stage, or an off-by-one window compare, therefore shows up as a shifted transition rather than a merely late one.

Directed pulses land on the boundary cycles c+T and c+T+1. A design that gave the timeout priority over a simultaneous edge would pulse high in the first case, and one that counted one cycle too many would never pulse in the second.

Randomly chosen periods on both channels, together with a one-sided stop and a mid-run reset, are compared cycle by cycle against a bench model. A shared counter, a leaked reset or a flag that did not hold would diverge from that model.

// File: rtl/lossig_pkg.sv
package lossig_pkg;

    // Default reference frequency and inactivity window.
    localparam int unsigned DEF_REF_MHZ   = 250;
    localparam int unsigned DEF_WINDOW_NS = 15000;

    // Number of reference cycles that make up a window of `ns` nanoseconds.
    function automatic int unsigned window_cycles(input int unsigned ref_mhz,
                                                  input int unsigned ns);
        return (ref_mhz * ns) / 1000;
    endfunction

endpackage

// File: rtl/lossig_toggle.sv
// Divide-by-two flop clocked by the monitored clock; every rising edge flips it.
module lossig_toggle (
    input  logic mon_clk,
    input  logic rst_n,
    output logic tog_o
);

    logic tog_d;
    logic tog_q;

    always_comb begin
        tog_d = ~tog_q;
    end

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign tog_o = tog_q;

endmodule

// File: rtl/lossig_edge_sync.sv
// Synchroniser chain into the reference domain followed by a change detector.
module lossig_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t cur_q;
    sync_t nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], async_i};
        nxt_d.last  = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // One-cycle pulse for every change of the synchronised toggle.
    assign edge_o = cur_q.chain[STAGES-1] ^ cur_q.last;

endmodule

// File: rtl/lossig_channel.sv
// Inactivity counter and loss flag for one monitored clock.
module lossig_channel #(
    parameter int unsigned TIMEOUT = 3750
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic los_o
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } chan_t;

    chan_t cur_q;
    chan_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (edge_i) begin
            // A detected edge wins over an expiring window in the same cycle.
            nxt_d.cnt  = '0;
            nxt_d.flag = 1'b0;
        end else if (cur_q.cnt != CNT_W'(TIMEOUT)) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
            if (cur_q.cnt == CNT_W'(TIMEOUT - 1)) begin
                nxt_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt  <= CNT_W'(TIMEOUT);
            cur_q.flag <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign los_o = cur_q.flag;

endmodule

// File: rtl/lossig_monitor.sv
module lossig_monitor #(
    parameter int unsigned NUM_INPUTS  = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REF_MHZ     = lossig_pkg::DEF_REF_MHZ,
    parameter int unsigned WINDOW_NS   = lossig_pkg::DEF_WINDOW_NS
) (
    input  logic                  ref_clk,
    input  logic                  rst_n,
    input  logic [NUM_INPUTS-1:0] mon_clk_i,
    output logic [NUM_INPUTS-1:0] los_o
);

    localparam int unsigned TIMEOUT_CYCLES = lossig_pkg::window_cycles(REF_MHZ, WINDOW_NS);

    logic [NUM_INPUTS-1:0] tog_w;
    logic [NUM_INPUTS-1:0] edge_w;

    for (genvar g = 0; g < NUM_INPUTS; g++) begin : gen_chan
        lossig_toggle u_tog (
            .mon_clk (mon_clk_i[g]),
            .rst_n   (rst_n),
            .tog_o   (tog_w[g])
        );

        lossig_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .async_i (tog_w[g]),
            .edge_o  (edge_w[g])
        );

        lossig_channel #(
            .TIMEOUT (TIMEOUT_CYCLES)
        ) u_chan (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .edge_i  (edge_w[g]),
            .los_o   (los_o[g])
        );
    end

endmodule

// File: rtl/lossig_checker.sv
module lossig_checker #(
    parameter int unsigned NUM     = 2,
    parameter int unsigned TIMEOUT = 3750
) (
    input logic           ref_clk,
    input logic           rst_n,
    input logic [NUM-1:0] edge_seen,
    input logic [NUM-1:0] los
);

    localparam int unsigned CW = $clog2(TIMEOUT + 1);

    for (genvar g = 0; g < NUM; g++) begin : gen_chk
        logic [CW-1:0] since_q;
        logic          seen_q;

        // Cycles since the last detected edge, saturating at the window.
        always_ff @(posedge ref_clk or negedge rst_n) begin
            if (!rst_n) begin
                since_q <= CW'(TIMEOUT);
                seen_q  <= 1'b0;
            end else if (edge_seen[g]) begin
                since_q <= '0;
                seen_q  <= 1'b1;
            end else if (since_q != CW'(TIMEOUT)) begin
                since_q <= since_q + CW'(1);
            end
        end

        a_r1_high_until_seen: assert property (@(posedge ref_clk) disable iff (!rst_n)
            !seen_q |-> los[g]);

        a_r2_clear_after_edge: assert property (@(posedge ref_clk) disable iff (!rst_n)
            edge_seen[g] |=> !los[g]);

        a_r3_rise_at_window: assert property (@(posedge ref_clk) disable iff (!rst_n)
            $rose(los[g]) |-> (since_q == CW'(TIMEOUT)));

        a_r5_low_inside_window: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (!los[g] && !edge_seen[g] && (since_q < CW'(TIMEOUT - 1))) |=> !los[g]);

        a_r7_hold_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (los[g] && !edge_seen[g]) |=> los[g]);
    end

endmodule

bind lossig_monitor lossig_checker #(
    .NUM     (NUM_INPUTS),
    .TIMEOUT (TIMEOUT_CYCLES)
) u_lossig_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .edge_seen (edge_w),
    .los       (los_o)
);

// File: tb/lossig_monitor_test.sv
`timescale 1ns/100ps
module lossig_monitor_test;

    localparam int T = 250 * 15000 / 1000;

    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] mon     = 2'b00;
    logic [1:0] los;

    bit  run  [2];
    int  half [2];
    int  cyc = 0;
    int  last_e [2];
    int  prev_e [2];
    bit  seen   [2];
    bit  pseen  [2];
    int  mism   = 0;
    int  checks = 0;
    int  fails  = 0;
    int  hi_cnt [2];

    lossig_monitor #(
        .NUM_INPUTS (2),
        .REF_MHZ    (250),
        .WINDOW_NS  (15000)
    ) uut (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .mon_clk_i (mon),
        .los_o     (los)
    );

    always #2 ref_clk = ~ref_clk;
    always @(posedge ref_clk) cyc = cyc + 1;

    // Monitored clock generators; all edges sit 0.3 ns off the ns grid.
    for (genvar g = 0; g < 2; g++) begin : gen_mon
        initial begin
            #0.3;
            forever begin
                if (run[g]) begin
                    #(half[g]) mon[g] = ~mon[g];
                end else begin
                    #1;
                end
            end
        end

        always @(posedge mon[g]) begin
            if (rst_n) begin
                prev_e[g] = last_e[g];
                pseen[g]  = seen[g];
                last_e[g] = cyc;
                seen[g]   = 1'b1;
            end
        end
    end

    // Bench model of the expected flag, built from R1, R2, R3.
    function automatic logic exp_los(input int i);
        if (!seen[i]) return 1'b1;
        if (cyc - last_e[i] >= 3) return (cyc - last_e[i] >= T + 3);
        if (!pseen[i]) return 1'b1;
        return (cyc - prev_e[i] >= T + 3);
    endfunction

    always @(negedge ref_clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (los[i] !== exp_los(i)) mism = mism + 1;
                if (los[i] === 1'b1) hi_cnt[i] = hi_cnt[i] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_check(input string tag, input string what);
        check(mism == 0, tag, what, mism, 0);
        mism = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic stop_clk(input int i);
        run[i] = 1'b0;
        #(half[i] + 1);
        mon[i] = 1'b0;
    endtask

    task automatic pulse_at(input int i, input int target);
        do @(negedge ref_clk); while (cyc < target);
        #1.3 mon[i] = 1'b1;
        #4   mon[i] = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge ref_clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int unsigned seed;
        int t0;
        int d;
        seed = $urandom(32'd20240611);

        // Reset state and R1.
        wait_cycles(5);
        check(los === 2'b11, "R6", "flags in reset", los, 3);
        rst_n = 1'b1;
        wait_cycles(50);
        check(los === 2'b11, "R1", "flags before any edge", los, 3);

        // R2 clear timing on channel 0, R4 isolation of channel 1.
        half[0] = 10;
        run[0]  = 1'b1;
        wait (seen[0]);
        t0 = last_e[0];
        d  = 0;
        while (los[0] !== 1'b0 && d < 100) begin
            @(negedge ref_clk);
            d = d + 1;
        end
        check(cyc - t0 == 3, "R2", "clear delay in cycles", cyc - t0, 3);
        check(los[1] === 1'b1, "R4", "idle channel stays flagged", los[1], 1);

        // Random periods on both channels, R5.
        half[1] = 12;
        run[1]  = 1'b1;
        mism    = 0;
        wait_cycles(20);
        mism = 0;
        for (int k = 0; k < 6; k++) begin
            half[0] = 8 + ($urandom % 193);
            half[1] = 8 + ($urandom % 193);
            wait_cycles(300 + ($urandom % 1200));
            model_check("R5", "random periods model mismatches");
            check(los === 2'b00, "R5", "both flags low while running", los, 0);
        end

        // R3 set timing on channel 1, R4 isolation of channel 0.
        stop_clk(1);
        d = 0;
        while (los[1] !== 1'b1 && d < T + 100) begin
            @(negedge ref_clk);
            d = d + 1;
        end
        check(cyc - last_e[1] == T + 3, "R3", "set delay in cycles", cyc - last_e[1], T + 3);
        check(los[0] === 1'b0, "R4", "running channel unaffected", los[0], 0);
        model_check("R7", "hold and set model mismatches");

        // R5 at 1 MHz on channel 1, with R2 clear.
        half[1] = 500;
        run[1]  = 1'b1;
        wait_cycles(4000);
        check(los[1] === 1'b0, "R5", "1 MHz clock keeps flag low", los[1], 0);
        model_check("R2", "slow clock model mismatches");

        // R3 boundary pulses on channel 0.
        stop_clk(0);
        wait_cycles(T + 20);
        check(los[0] === 1'b1, "R7", "stopped channel flagged", los[0], 1);
        pulse_at(0, cyc + 2);
        t0 = last_e[0];
        wait_cycles(10);
        hi_cnt[0] = 0;
        pulse_at(0, t0 + T);
        t0 = last_e[0];
        wait_cycles(10);
        check(hi_cnt[0] == 0, "R3", "edge at window end keeps flag low", hi_cnt[0], 0);
        hi_cnt[0] = 0;
        pulse_at(0, t0 + T + 1);
        wait_cycles(10);
        check(hi_cnt[0] == 1, "R3", "edge one past window gives one-cycle flag", hi_cnt[0], 1);
        model_check("R3", "boundary model mismatches");

        // R6 reset while both clocks run.
        half[0] = 9;
        run[0]  = 1'b1;
        wait_cycles(300);
        @(negedge ref_clk);
        rst_n = 1'b0;
        seen[0] = 1'b0; seen[1] = 1'b0;
        pseen[0] = 1'b0; pseen[1] = 1'b0;
        #1;
        check(los === 2'b11, "R6", "flags set by reset", los, 3);
        wait_cycles(3);
        check(los === 2'b11, "R6", "clock edges ignored in reset", los, 3);
        rst_n = 1'b1;
        wait_cycles(600);
        check(los === 2'b00, "R6", "flags clear after release", los, 0);
        model_check("R6", "post-reset model mismatches");

        finish_run();
    end

endmodule